// File: doc/BRIEF.md
# Banked Memory Window Mapper for an 8-bit Sound CPU

This block sits between an 8-bit CPU with a 16-bit address bus and a large program ROM. It turns each CPU address into either a 19-bit physical ROM address or an access to a private 2 KB work RAM. The lower 32 KB of the CPU space always shows the start of the ROM. Above it are four switchable windows of 16, 8, 4 and 2 KB, each backed by its own bank register. The top 2 KB is the work RAM.

Software picks a bank by issuing an I/O cycle. A window index says which bank register to load, and the upper byte of the 16-bit port address carries the bank number. Each window keeps only as many low bits of that byte as it has banks. The whole 16-bit port value is stored and can be read back, so a save/restore routine can capture the mapping and replay it later. Address decode is purely combinational. A bank load takes effect at the next clock edge.

Top module: `cpu_window_mapper`

## Requirements
- R1: A read at any CPU address 0x0000–0x7FFF asserts `rom_sel` and drives `rom_addr` with the same value zero-extended to 19 bits.
- R2: A read in 0x8000–0xBFFF drives `rom_addr` = bits [11:8] of window 0's stored port value × 0x4000 + (CPU address − 0x8000).
- R3: A read in 0xC000–0xDFFF drives `rom_addr` = bits [12:8] of window 1's stored port value × 0x2000 + (CPU address − 0xC000).
- R4: A read in 0xE000–0xEFFF drives `rom_addr` = bits [13:8] of window 2's stored port value × 0x1000 + (CPU address − 0xE000).
- R5: A read in 0xF000–0xF7FF drives `rom_addr` = bits [14:8] of window 3's stored port value × 0x0800 + (CPU address − 0xF000).
- R6: In 0xF800–0xFFFF, reads and writes assert `ram_rd` and `ram_wr` and never `rom_sel`. A byte written there appears on `ram_rdata` the cycle after a later read of the same address.
- R7: A write below 0xF800 asserts neither `ram_wr` nor `rom_sel`, and it does not change the work RAM.
- R8: After reset the stored port values are 0x0200, 0x0600, 0x0E00 and 0x1E00 for windows 0–3. Each window therefore maps to physical 0x8000, 0xC000, 0xE000 and 0xF000, which is the same as its own CPU address.
- R9: `rb_port` returns the full 16-bit port value last loaded into the window selected by `rb_sel`, including the bits the mapping ignores.
- R10: A bank load with `bsel_idx` of 4 to 7 changes no stored port value and no mapping.
- R11: A bank load is stored at the clock edge where `bsel_wr` is high. A read in that same cycle still uses the old mapping, and a read in the next cycle uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | CPU memory read |
| mem_wr | input | 1 | CPU memory write |
| cpu_wdata | input | 8 | CPU write data |
| bsel_wr | input | 1 | Bank-select I/O write strobe |
| bsel_idx | input | 3 | Window index of the bank load (0–3 valid) |
| bsel_port | input | 16 | Full I/O port address; the upper byte carries the bank |
| rb_sel | input | 2 | Window whose stored port value is read back |
| rb_port | output | 16 | Stored port value of the selected window |
| rom_addr | output | 19 | Physical ROM address |
| rom_sel | output | 1 | ROM read select |
| ram_rd | output | 1 | Work RAM read strobe |
| ram_wr | output | 1 | Work RAM write strobe |
| ram_rdata | output | 8 | Work RAM read data, one cycle after the read |

## Verification
A bank load and a memory read through the same window can arrive in one cycle. The bench provokes this by raising `bsel_wr` for window 1 while it holds a read at 0xC010. In that cycle it expects `rom_addr` from the old bank. It keeps the address and checks again one cycle later, expecting the new bank. Separate scenarios cover every region edge, the highest bank each mask allows (with the masked-off bits set), writes aimed at ROM, and loads with an out-of-range window index.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  localparam int CPU_AW      = 16;
  localparam int ROM_AW      = 19;
  localparam int NWIN        = 4;
  localparam int IDX_W       = $clog2(NWIN) + 1;
  localparam int RAM_AW      = 11;
  localparam int DATA_W      = 8;
  localparam int TOP_SHIFT   = 14;  // log2 of the largest window
  localparam int BANK_MIN_W  = 4;   // bank width of the largest window
  localparam int PORT_BANK_LSB = 8;

  // Reset port value: bank that maps window i onto its own CPU address.
  function automatic logic [CPU_AW-1:0] rst_port(input int i);
    int unsigned base;
    int unsigned bank;
    base = 32'h1_0000 - (32'h1 << (CPU_AW - 1 - i));
    bank = base >> (TOP_SHIFT - i);
    return CPU_AW'(bank << PORT_BANK_LSB);
  endfunction
endpackage

// File: rtl/cwm_bank_regs.sv
module cwm_bank_regs
  import cwm_pkg::*;
#(
  parameter int N  = NWIN,
  parameter int IW = IDX_W,
  parameter int PW = CPU_AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [IW-1:0]        ld_idx,
  input  logic [PW-1:0]        ld_val,
  input  logic [$clog2(N)-1:0] rd_sel,
  output logic [N-1:0][PW-1:0] regs,
  output logic [PW-1:0]        rd_val
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic          en;
    logic [PW-1:0] nxt;
    always_comb begin
      en  = ld && (ld_idx == IW'(i));
      nxt = en ? ld_val : regs[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= rst_port(i);
      else if (en) regs[i] <= nxt;
    end
  end

  assign rd_val = regs[rd_sel];
endmodule

// File: rtl/cwm_decode.sv
module cwm_decode
  import cwm_pkg::*;
#(
  parameter int N  = NWIN,
  parameter int AW = CPU_AW,
  parameter int RW = ROM_AW
) (
  input  logic [AW-1:0]        addr,
  input  logic [N-1:0][AW-1:0] ports,
  output logic                 in_ram,
  output logic [RW-1:0]        phys
);
  logic [N-1:0]         hit;
  logic [N-1:0][RW-1:0] cand;

  for (genvar i = 0; i < N; i++) begin : g_win
    localparam int SH = TOP_SHIFT - i;
    localparam int BW = BANK_MIN_W + i;
    assign hit[i]  = (addr[AW-1 -: i+2] == {{(i+1){1'b1}}, 1'b0});
    assign cand[i] = RW'({ports[i][PORT_BANK_LSB +: BW], addr[SH-1:0]});
  end

  assign in_ram = &addr[AW-1 -: N+1];

  always_comb begin
    phys = RW'(addr);
    for (int i = 0; i < N; i++) begin
      if (hit[i]) phys = cand[i];
    end
  end
endmodule

// File: rtl/cwm_ram.sv
module cwm_ram
  import cwm_pkg::*;
#(
  parameter int AW = RAM_AW,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/cpu_window_mapper.sv
module cpu_window_mapper
  import cwm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CPU_AW-1:0]         cpu_addr,
  input  logic                      mem_rd,
  input  logic                      mem_wr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  input  logic                      bsel_wr,
  input  logic [IDX_W-1:0]          bsel_idx,
  input  logic [CPU_AW-1:0]         bsel_port,
  input  logic [$clog2(NWIN)-1:0]   rb_sel,
  output logic [CPU_AW-1:0]         rb_port,
  output logic [ROM_AW-1:0]         rom_addr,
  output logic                      rom_sel,
  output logic                      ram_rd,
  output logic                      ram_wr,
  output logic [DATA_W-1:0]         ram_rdata
);
  logic [1:0]                  rst_sync;
  logic                        rst_int_n;
  logic [NWIN-1:0][CPU_AW-1:0] ports;
  logic                        in_ram;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  cwm_bank_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .ld(bsel_wr), .ld_idx(bsel_idx),
    .ld_val(bsel_port), .rd_sel(rb_sel), .regs(ports), .rd_val(rb_port)
  );

  cwm_decode u_dec (
    .addr(cpu_addr), .ports(ports), .in_ram(in_ram), .phys(rom_addr)
  );

  always_comb begin
    rom_sel = mem_rd && !in_ram;
    ram_rd  = mem_rd && in_ram;
    ram_wr  = mem_wr && in_ram;
  end

  cwm_ram u_ram (
    .clk(clk), .we(ram_wr), .re(ram_rd), .addr(cpu_addr[RAM_AW-1:0]),
    .wdata(cpu_wdata), .rdata(ram_rdata)
  );
endmodule

// File: rtl/cwm_checker.sv
module cwm_checker
  import cwm_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [CPU_AW-1:0]       cpu_addr,
  input logic                    mem_rd,
  input logic                    mem_wr,
  input logic                    bsel_wr,
  input logic [IDX_W-1:0]        bsel_idx,
  input logic [CPU_AW-1:0]       bsel_port,
  input logic [$clog2(NWIN)-1:0] rb_sel,
  input logic [CPU_AW-1:0]       rb_port,
  input logic [ROM_AW-1:0]       rom_addr,
  input logic                    rom_sel,
  input logic                    ram_rd,
  input logic                    ram_wr
);
  // R1
  fixed_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !cpu_addr[CPU_AW-1]) |-> (rom_sel && rom_addr == ROM_AW'(cpu_addr)));

  // R6
  ram_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && (ram_rd || ram_wr)));

  // R7
  rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_rd) |-> (!rom_sel && (ram_wr == (&cpu_addr[CPU_AW-1 -: NWIN+1]))));

  // R9
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bsel_wr && !bsel_idx[IDX_W-1] && bsel_idx[IDX_W-2:0] == rb_sel)
    |=> (rb_sel != $past(rb_sel)) || (rb_port == $past(bsel_port)));

  // R10
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bsel_wr || bsel_idx[IDX_W-1])
    |=> (rb_sel != $past(rb_sel)) || $stable(rb_port));
endmodule

bind cpu_window_mapper cwm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .bsel_wr(bsel_wr), .bsel_idx(bsel_idx), .bsel_port(bsel_port), .rb_sel(rb_sel),
  .rb_port(rb_port), .rom_addr(rom_addr), .rom_sel(rom_sel), .ram_rd(ram_rd),
  .ram_wr(ram_wr)
);

// File: tb/cpu_window_mapper_tb_top.sv
module cpu_window_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  cpu_wdata;
  logic        bsel_wr;
  logic [2:0]  bsel_idx;
  logic [15:0] bsel_port;
  logic [1:0]  rb_sel;
  logic [15:0] rb_port;
  logic [18:0] rom_addr;
  logic        rom_sel, ram_rd, ram_wr;
  logic [7:0]  ram_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] mdl [4];

  always #4 clk = ~clk;

  cpu_window_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cpu_wdata(cpu_wdata), .bsel_wr(bsel_wr), .bsel_idx(bsel_idx), .bsel_port(bsel_port),
    .rb_sel(rb_sel), .rb_port(rb_port), .rom_addr(rom_addr), .rom_sel(rom_sel),
    .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_rdata(ram_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model(input logic [15:0] a);
    int ai = int'(a);
    if (ai < 'h8000) return ai;
    if (ai < 'hC000) return ((mdl[0] >> 8) & 'h0F) * 'h4000 + (ai - 'h8000);
    if (ai < 'hE000) return ((mdl[1] >> 8) & 'h1F) * 'h2000 + (ai - 'hC000);
    if (ai < 'hF000) return ((mdl[2] >> 8) & 'h3F) * 'h1000 + (ai - 'hE000);
    return ((mdl[3] >> 8) & 'h7F) * 'h0800 + (ai - 'hF000);
  endfunction

  task automatic bank_load(input int idx, input logic [15:0] p);
    @(negedge clk);
    bsel_wr = 1'b1; bsel_idx = 3'(idx); bsel_port = p;
    @(negedge clk);
    bsel_wr = 1'b0;
    if (idx < 4) mdl[idx] = p;
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; mem_rd = 1'b1; mem_wr = 1'b0;
    #2;
    chk(req, int'(rom_sel), 1);
    chk(req, int'(rom_addr), model(a));
    mem_rd = 1'b0;
  endtask

  task automatic readback(input string req, input int w, input int exp);
    rb_sel = 2'(w);
    #1;
    chk(req, int'(rb_port), exp);
  endtask

  task automatic ram_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; mem_wr = 1'b1; mem_rd = 1'b0; cpu_wdata = d;
    #2;
    chk("R6 write strobe", int'(ram_wr), 1);
    chk("R6 no rom on write", int'(rom_sel), 0);
    @(negedge clk);
    mem_wr = 1'b0;
  endtask

  task automatic ram_read(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; mem_rd = 1'b1; mem_wr = 1'b0;
    #2;
    chk("R6 read strobe", int'(ram_rd), 1);
    chk("R6 no rom on ram read", int'(rom_sel), 0);
    @(negedge clk);
    mem_rd = 1'b0;
    #1;
    chk("R6 read data", int'(ram_rdata), int'(d));
  endtask

  task automatic t_reset;
    #2;
    chk("R8 idle rom_sel", int'(rom_sel), 0);
    chk("R8 idle ram_wr", int'(ram_wr), 0);
    readback("R8 w0 reset", 0, 'h0200);
    readback("R8 w1 reset", 1, 'h0600);
    readback("R8 w2 reset", 2, 'h0E00);
    readback("R8 w3 reset", 3, 'h1E00);
    probe("R8 w0 identity", 16'h8000);
    chk("R8 w0 abs", int'(rom_addr), 'h8000);
    probe("R8 w1 identity", 16'hC000);
    chk("R8 w1 abs", int'(rom_addr), 'hC000);
    probe("R8 w2 identity", 16'hE000);
    chk("R8 w2 abs", int'(rom_addr), 'hE000);
    probe("R8 w3 identity", 16'hF7FF);
    chk("R8 w3 abs", int'(rom_addr), 'hF7FF);
  endtask

  task automatic t_fixed;
    probe("R1 low edge", 16'h0000);
    probe("R1 mid", 16'h1234);
    probe("R1 top edge", 16'h7FFF);
  endtask

  task automatic t_windows;
    bank_load(0, 16'h0500);
    bank_load(1, 16'h0900);
    bank_load(2, 16'h1300);
    bank_load(3, 16'h2500);
    probe("R2 first", 16'h8000);
    probe("R2 last", 16'hBFFF);
    probe("R3 first", 16'hC000);
    probe("R3 last", 16'hDFFF);
    probe("R4 first", 16'hE000);
    probe("R4 last", 16'hEFFF);
    probe("R5 first", 16'hF000);
    probe("R5 last", 16'hF7FF);
  endtask

  task automatic t_maxbank;
    for (int w = 0; w < 4; w++) bank_load(w, 16'hFF00);
    probe("R2 max bank", 16'hBFFF);
    chk("R2 max abs", int'(rom_addr), 'h3FFFF);
    probe("R3 max bank", 16'hC000);
    chk("R3 max abs", int'(rom_addr), 'h3E000);
    probe("R4 max bank", 16'hE001);
    chk("R4 max abs", int'(rom_addr), 'h3F001);
    probe("R5 max bank", 16'hF000);
    chk("R5 max abs", int'(rom_addr), 'h3F800);
  endtask

  task automatic t_ram;
    ram_write(16'hF800, 8'hA5);
    ram_write(16'hFFFF, 8'h3C);
    ram_read(16'hF800, 8'hA5);
    ram_read(16'hFFFF, 8'h3C);
  endtask

  task automatic t_rom_write;
    ram_write(16'hF801, 8'h77);
    foreach (mdl[k]) begin end
    begin
      logic [15:0] addrs [4] = '{16'h0001, 16'h8801, 16'hF7FF, 16'hE801};
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        cpu_addr = addrs[k]; mem_wr = 1'b1; cpu_wdata = 8'h00;
        #2;
        chk("R7 no ram_wr", int'(ram_wr), 0);
        chk("R7 no rom_sel", int'(rom_sel), 0);
      end
      @(negedge clk);
      mem_wr = 1'b0;
    end
    ram_read(16'hF801, 8'h77);
  endtask

  task automatic t_readback;
    bank_load(2, 16'hABCD);
    readback("R9 full value", 2, 'hABCD);
    probe("R9 masked use", 16'hE010);
    chk("R9 abs", int'(rom_addr), 'h2B010);
  endtask

  task automatic t_bad_index;
    for (int idx = 4; idx < 8; idx++) bank_load(idx, 16'h1100);
    for (int w = 0; w < 4; w++) readback("R10 unchanged", w, int'(mdl[w]));
    probe("R10 map w0", 16'h8123);
    probe("R10 map w3", 16'hF456);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cpu_addr = 16'hC010; mem_rd = 1'b1;
    bsel_wr = 1'b1; bsel_idx = 3'd1; bsel_port = 16'h0500;
    #2;
    chk("R11 old map same cycle", int'(rom_addr), model(16'hC010));
    @(negedge clk);
    bsel_wr = 1'b0;
    mdl[1] = 16'h0500;
    #2;
    chk("R11 new map next cycle", int'(rom_addr), 'hA010);
    mem_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = '0; mem_rd = 1'b0; mem_wr = 1'b0; cpu_wdata = '0;
    bsel_wr = 1'b0; bsel_idx = '0; bsel_port = '0; rb_sel = '0;
    mdl[0] = 16'h0200; mdl[1] = 16'h0600; mdl[2] = 16'h0E00; mdl[3] = 16'h1E00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fixed();
    t_windows();
    t_maxbank();
    t_ram();
    t_rom_write();
    t_readback();
    t_bad_index();
    t_same_cycle();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule